// File: doc/BRIEF.md
# Parallel prefix adder

A purely combinational N-bit binary adder whose carries come from a prefix tree instead of a ripple chain. Each bit first produces a generate flag (both operand bits set) and a propagate flag (operand bits differ). A network of combining cells then forms, for every bit position, the group generate that spans from that position down to the carry-in. Finally, each sum bit is its propagate flag XORed with the carry arriving at that bit.

The carry-in is folded in as an extra node below bit 0. That node has generate equal to the carry-in and propagate held at zero. As a result, every finished prefix node is the carry into the next bit. A black cell forms both the group generate and the group propagate. A grey cell forms the generate only. A grey cell is placed wherever the span it produces reaches the carry-in node, because the group propagate is zero there. A buffer passes a node on unchanged.

The `TOPOLOGY` parameter picks how the cells are arranged:

| Value | Arrangement |
|---|---|
| 0 | Kogge-Stone |
| 1 | Brent-Kung |
| 2 | Han-Carlson |
| 3 | Ladner-Fischer |

The block is used wherever a wide add must settle in one cycle. The surrounding logic registers the operands and the result.

Top module: `ppa_adder`

## Requirements
- R1: For every `WIDTH` and `TOPOLOGY`, `{carry_out, sum}` equals `a + b + carry_in` computed at `WIDTH+1` bits.
- R2: Bit i generates when `a[i] & b[i]` and propagates when `a[i] ^ b[i]`; no bit does both. With `a == b` no bit propagates, so the result is `a` shifted left by one with `carry_in` in bit 0.
- R3: The carry-in acts as the carry into bit 0. With `a` all ones, `b` zero and `carry_in` 1, `sum` is zero and `carry_out` is 1.
- R4: A carry crosses the full width through propagate-only bits. With alternating patterns (`a` = ...0101, `b` = ...1010), `sum` is all ones and `carry_out` is 0 when `carry_in` is 0. When `carry_in` is 1, `sum` is zero and `carry_out` is 1.
- R5: With `a` and `b` all ones and `carry_in` 1, every bit generates: `sum` is all ones and `carry_out` is 1.
- R6: With zero operands, `sum` equals `carry_in` and `carry_out` is 0.
- R7: The carry into bit i+1 equals `g[i] | (p[i] & c[i])`. A generate at bit 0 with propagate above it sets `carry_out`.
- R8: `TOPOLOGY` values 0 (Kogge-Stone), 1 (Brent-Kung), 2 (Han-Carlson) and 3 (Ladner-Fischer) all give identical `sum` and `carry_out` for identical inputs.
- R9: `WIDTH` may be any value from 1 to 256. Widths 8, 32 and 256 are exercised.
- R10: A grey cell is used only where both of its inputs' group propagates cannot be 1 together, that is, where the produced span reaches the carry-in node.
- R11: The outputs depend only on the present inputs. When the inputs change, the new result is valid within the same cycle, with no state carried over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that must cross every bit through propagate-only positions. This case exercises the longest spans of the prefix tree and every grey cell at its edge. Uniform random operands almost never produce it at 256 bits. The stimulus therefore forces it directly, using alternating operand patterns and all-ones-plus-zero operands, each with the carry-in both clear and set. It also places a single generate at bit 0 beneath a full run of propagates. All twelve combinations of width and topology see the same inputs in the same cycle and are compared against a bit-serial reference.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  localparam int TOPO_KOGGE_STONE    = 0;
  localparam int TOPO_BRENT_KUNG     = 1;
  localparam int TOPO_HAN_CARLSON    = 2;
  localparam int TOPO_LADNER_FISCHER = 3;

  // Number of combining levels for a tree over 2^lg nodes.
  function automatic int tree_levels(input int topo, input int lg);
    case (topo)
      TOPO_BRENT_KUNG:  return (lg <= 1) ? lg : (2 * lg - 1);
      TOPO_HAN_CARLSON: return lg + 1;
      default:          return lg;
    endcase
  endfunction

  // Lower node combined into node nd at level lv, or -1 for a buffer.
  function automatic int cell_partner(input int topo, input int lg,
                                      input int lv, input int nd);
    int d;
    int k;
    case (topo)
      TOPO_BRENT_KUNG: begin
        if (lv < lg) begin
          d = 1 << lv;
          return (((nd + 1) % (2 * d)) == 0) ? nd - d : -1;
        end
        k = 2 * lg - 2 - lv;
        d = 1 << k;
        return ((((nd + 1) % (2 * d)) == d) && (nd + 1 > 2 * d)) ? nd - d : -1;
      end
      TOPO_HAN_CARLSON: begin
        if (lv == 0) return ((nd % 2) == 1) ? nd - 1 : -1;
        if (lv < lg) begin
          d = 1 << lv;
          return (((nd % 2) == 1) && (nd > d)) ? nd - d : -1;
        end
        return (((nd % 2) == 0) && (nd >= 2)) ? nd - 1 : -1;
      end
      TOPO_LADNER_FISCHER: begin
        return (((nd >> lv) % 2) == 1) ? (((nd >> lv) << lv) - 1) : -1;
      end
      default: begin
        d = 1 << lv;
        return (nd >= d) ? nd - d : -1;
      end
    endcase
  endfunction

  // A cell is grey when its lower input already spans down to node 0.
  function automatic bit cell_is_grey(input int topo, input int lg,
                                      input int lv, input int nd);
    int q;
    q = cell_partner(topo, lg, lv, nd);
    if ((topo == TOPO_BRENT_KUNG) && (lv >= lg)) return 1'b1;
    if ((topo == TOPO_HAN_CARLSON) && (lv == lg)) return 1'b1;
    return (q < (1 << lv));
  endfunction

endpackage

// File: rtl/ppa_bit_gp.sv
module ppa_bit_gp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g_bit,
  output logic [WIDTH-1:0] p_bit
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit_gp
    assign g_bit[i] = a[i] & b[i];
    assign p_bit[i] = a[i] ^ b[i];
  end

  // R2: a bit never both generates and propagates
  always_comb begin
    a_r2_gen_prop_disjoint: assert ((g_bit & p_bit) == '0);
  end

endmodule

// File: rtl/ppa_prefix_cell.sv
module ppa_prefix_cell #(
  parameter bit BLACK = 1'b1
) (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);

  assign g_out = g_hi | (p_hi & g_lo);

  if (BLACK) begin : g_black
    assign p_out = p_hi & p_lo;
  end else begin : g_grey
    // Span reaches the carry-in node, whose propagate is zero.
    assign p_out = 1'b0;
    always_comb begin
      a_r10_grey_span_closed: assert (!(p_hi && p_lo));
    end
  end

endmodule

// File: rtl/ppa_carry_tree.sv
module ppa_carry_tree
  import ppa_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int TOPOLOGY = TOPO_KOGGE_STONE
) (
  input  logic [WIDTH-1:0] g_bit,
  input  logic [WIDTH-1:0] p_bit,
  input  logic             carry_in,
  output logic [WIDTH:0]   carry
);

  localparam int NODES  = WIDTH + 1;
  localparam int LG     = $clog2(NODES);
  localparam int LEVELS = tree_levels(TOPOLOGY, LG);

  logic [NODES-1:0] gs [LEVELS+1];
  logic [NODES-1:0] ps [LEVELS+1];

  // Node 0 carries the carry-in; node i+1 holds bit i.
  assign gs[0] = {g_bit, carry_in};
  assign ps[0] = {p_bit, 1'b0};

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    for (genvar nd = 0; nd < NODES; nd++) begin : g_node
      localparam int PARTNER = cell_partner(TOPOLOGY, LG, lv, nd);
      if (PARTNER < 0) begin : g_buf
        assign gs[lv+1][nd] = gs[lv][nd];
        assign ps[lv+1][nd] = ps[lv][nd];
      end else begin : g_cell
        localparam bit IS_BLACK = !cell_is_grey(TOPOLOGY, LG, lv, nd);
        ppa_prefix_cell #(.BLACK(IS_BLACK)) u_cell (
          .g_hi (gs[lv][nd]),
          .p_hi (ps[lv][nd]),
          .g_lo (gs[lv][PARTNER]),
          .p_lo (ps[lv][PARTNER]),
          .g_out(gs[lv+1][nd]),
          .p_out(ps[lv+1][nd])
        );
      end
    end
  end

  assign carry = gs[LEVELS];

  // R10: every finished node spans down to the carry-in node
  always_comb begin
    a_r10_all_spans_closed: assert (ps[LEVELS] == '0);
  end

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] p_bit,
  input  logic [WIDTH:0]   carry,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  assign sum       = p_bit ^ carry[WIDTH-1:0];
  assign carry_out = carry[WIDTH];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
  import ppa_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int TOPOLOGY = TOPO_KOGGE_STONE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  logic [WIDTH-1:0] g_bit;
  logic [WIDTH-1:0] p_bit;
  logic [WIDTH:0]   carry;

  ppa_bit_gp #(.WIDTH(WIDTH)) u_gp (
    .a    (a),
    .b    (b),
    .g_bit(g_bit),
    .p_bit(p_bit)
  );

  ppa_carry_tree #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY)) u_tree (
    .g_bit   (g_bit),
    .p_bit   (p_bit),
    .carry_in(carry_in),
    .carry   (carry)
  );

  ppa_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .p_bit    (p_bit),
    .carry    (carry),
    .sum      (sum),
    .carry_out(carry_out)
  );

  // R7: tree carries obey the bit-serial recurrence
  always_comb begin
    a_r7_carry_in_first: assert (carry[0] == carry_in);
    for (int i = 0; i < WIDTH; i++) begin
      a_r7_carry_recurrence: assert (carry[i+1] == (g_bit[i] | (p_bit[i] & carry[i])));
    end
  end

  // R1: result equals the arithmetic sum
  always_comb begin
    a_r1_sum_matches: assert ({carry_out, sum} ==
      ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in}));
  end

endmodule

// File: tb/ppa_adder_bench.sv
`timescale 1ns/1ps
module ppa_adder_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [255:0] op_a = '0;
  logic [255:0] op_b = '0;
  logic         cin  = 1'b0;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  logic [256:0] res [3][4];

  function automatic int width_of(input int wi);
    return (wi == 0) ? 8 : (wi == 1) ? 32 : 256;
  endfunction

  // R8 R9: every topology at every width sees the same inputs
  for (genvar wi = 0; wi < 3; wi++) begin : g_w
    for (genvar ti = 0; ti < 4; ti++) begin : g_t
      localparam int W = (wi == 0) ? 8 : (wi == 1) ? 32 : 256;
      logic [W-1:0] s;
      logic         co;
      ppa_adder #(.WIDTH(W), .TOPOLOGY(ti)) u_ppa_adder (
        .a        (op_a[W-1:0]),
        .b        (op_b[W-1:0]),
        .carry_in (cin),
        .sum      (s),
        .carry_out(co)
      );
      assign res[wi][ti] = 257'(s) | (257'(co) << W);
    end
  end

  // Bit-serial reference
  function automatic logic [256:0] ripple(input logic [255:0] x,
                                          input logic [255:0] y,
                                          input logic c, input int w);
    logic [256:0] r;
    logic cc;
    r  = '0;
    cc = c;
    for (int i = 0; i < w; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc   = (x[i] & y[i]) | (cc & (x[i] ^ y[i]));
    end
    r[w] = cc;
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic apply(input string tag, input logic [255:0] x,
                       input logic [255:0] y, input logic c);
    logic [256:0] exp;
    @(negedge clk);
    op_a = x;
    op_b = y;
    cin  = c;
    @(posedge clk);
    #1;
    for (int wi = 0; wi < 3; wi++) begin
      for (int ti = 0; ti < 4; ti++) begin
        exp = ripple(x, y, c, width_of(wi));
        checks++;
        if (res[wi][ti] !== exp) begin
          failures++;
          $display("FAIL %s width=%0d topo=%0d actual=%h expected=%h",
                   tag, width_of(wi), ti, res[wi][ti], exp);
        end
      end
    end
  endtask

  localparam logic [255:0] ONES = {256{1'b1}};
  localparam logic [255:0] ALT1 = {128{2'b01}};
  localparam logic [255:0] ALT2 = {128{2'b10}};

  initial begin
    repeat (3) @(posedge clk);
    apply("R6", '0, '0, 1'b0);            // idle state: all zero
    apply("R6", '0, '0, 1'b1);
    apply("R3", ONES, '0, 1'b1);
    apply("R3", '0, ONES, 1'b1);
    apply("R4", ALT1, ALT2, 1'b0);
    apply("R4", ALT1, ALT2, 1'b1);
    apply("R4", ALT2, ALT1, 1'b1);
    apply("R5", ONES, ONES, 1'b1);
    apply("R5", ONES, ONES, 1'b0);
    apply("R7", 256'd1, ONES - 256'd1, 1'b0);
    apply("R7", 256'd1, ONES, 1'b0);
    apply("R2", ALT1, ALT1, 1'b1);
    apply("R2", ALT2, ALT2, 1'b0);
    // R11: back-to-back changes with no settling gap
    apply("R11", ONES, ONES, 1'b1);
    apply("R11", '0, '0, 1'b0);
    apply("R11", ONES, 256'd1, 1'b0);
    for (int n = 0; n < 120; n++) apply("R1", rnd256(), rnd256(), 1'($urandom));
    for (int n = 0; n < 60; n++) apply("R8", rnd256(), rnd256(), 1'($urandom));
    for (int n = 0; n < 60; n++) begin
      logic [255:0] x;
      x = rnd256();
      apply("R10", x, ~x, 1'($urandom));   // long propagate runs
    end
    for (int n = 0; n < 60; n++) begin
      logic [255:0] x;
      x = rnd256();
      apply("R9", x, rnd256() & x, 1'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule